// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Controller

This block gathers completion events from a CAN controller with up to 64 message buffers. Each buffer has a sticky flag and a mask bit. When a buffer finishes a transmission or a reception, its flag is set. A buffer raises an interrupt while its flag and its mask bit are both set. A single combined interrupt is high while any buffer interrupt is high. The CPU reaches the block through a register port of 32-bit words. Flags are write-one-to-clear, and masks are written directly.

When receive-FIFO mode is on, the lowest eight flag positions change meaning:

- Position 7 records FIFO overflow.
- Position 6 records FIFO warning.
- Position 5 records that frames are available.
- Positions 4 to 0 are dead.

A configured buffer count limits which flag positions are live. Positions at or above the count hold zero and never interrupt.

Top module: `mbflag_ctrl`

## Requirements
- R1: After reset every flag and every mask reads as zero, and `buf_irq` and `any_irq` are low.
- R2: A one-cycle pulse on `mb_done[i]` sets flag i on the next clock edge if lane i is live. Flag i appears at bit i%32 of word i/32. Transmit and receive completions are treated the same.
- R3: A write with `wr_sel`=2'b00 (low flag word) or 2'b01 (high flag word) clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: If a set event and a clear write hit the same flag in one cycle, the flag ends up set.
- R5: `buf_irq[i]` is high exactly when flag i is set, mask i is set and lane i is live.
- R6: `any_irq` is the OR of all bits of `buf_irq`.
- R7: While `cfg_fifo_en` is 1:
  - `fifo_ovf` sets flag 7, `fifo_warn` sets flag 6 and `fifo_avail` sets flag 5.
  - `mb_done[7:0]` is ignored.
  - Flags 4 to 0 read as zero and never interrupt.
  - Flags 7 to 5 keep their value across a mode change.
- R8: Lane i is live only if i < `cfg_nbuf` (values above 64 act as 64). Flags and interrupts of lanes that are not live are zero, and set events for them are ignored.
- R9: When `cfg_nbuf` or `cfg_fifo_en` changes, flags that become unused read as zero in the same cycle. They are also cleared in storage, so they stay zero if the lane becomes live again.
- R10: A write with `wr_sel`=2'b10 (low mask) or 2'b11 (high mask) loads that mask word. `rd_sel` selects a word with the same encoding, and reading has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nbuf | input | 7 | Number of live message buffers (0 to 64) |
| cfg_fifo_en | input | 1 | Receive-FIFO mode enable |
| mb_done | input | 64 | Per-buffer completion pulses |
| fifo_ovf | input | 1 | FIFO overflow event pulse |
| fifo_warn | input | 1 | FIFO warning event pulse |
| fifo_avail | input | 1 | FIFO frames-available event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: bit 1 selects mask (1) or flag (0), bit 0 selects the high word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding as `wr_sel` |
| rd_data | output | 32 | Selected word, live lanes only for flags |
| buf_irq | output | 64 | Per-buffer interrupt |
| any_irq | output | 1 | Combined interrupt |

## Verification
The bench first uses single-bit pulses and walking ones on `mb_done`. These separate an error in the word or bit placement from a stuck or crossed lane. Clear writes then use checkerboard data, both alone and in the same cycle as pulses on the same lanes, to tell write-one-to-clear apart from plain overwrite and to show that a set wins over a clear. Later phases vary the buffer count and toggle FIFO mode while flags are pending. This shows that dead lanes disappear at once and stay cleared, and that the FIFO pulses land on the remapped positions. A long random phase mixes all inputs and checks every output against the reference model on every clock.

// File: rtl/mbflag_pkg.sv
package mbflag_pkg;
  localparam int MB_MAX     = 64;
  localparam int MB_WORD    = 32;
  localparam int MB_NWORD   = MB_MAX / MB_WORD;
  localparam int MB_CNT_W   = $clog2(MB_MAX + 1);
  localparam int FIFO_OVF   = 7;
  localparam int FIFO_WARN  = 6;
  localparam int FIFO_AVAIL = 5;
  localparam int FIFO_SPAN  = 8;

  typedef enum logic [1:0] {
    SEL_FLAG_LO = 2'b00,
    SEL_FLAG_HI = 2'b01,
    SEL_MASK_LO = 2'b10,
    SEL_MASK_HI = 2'b11
  } reg_sel_e;

  // Live lanes: below the configured count, minus dead FIFO lanes.
  function automatic logic [MB_MAX-1:0] live_lanes(input logic [MB_CNT_W-1:0] cnt,
                                                   input logic fifo);
    logic [MB_MAX-1:0] v;
    for (int i = 0; i < MB_MAX; i++) begin
      v[i] = (i < int'(cnt));
      if (fifo && i < FIFO_AVAIL) v[i] = 1'b0;
    end
    return v;
  endfunction
endpackage

// File: rtl/mbflag_srcmap.sv
module mbflag_srcmap
  import mbflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [MB_MAX-1:0] done,
  input  logic              ev_ovf,
  input  logic              ev_warn,
  input  logic              ev_avail,
  output logic [MB_MAX-1:0] set_vec
);
  logic [FIFO_SPAN-1:0] fifo_low;

  always_comb begin
    fifo_low             = '0;
    fifo_low[FIFO_OVF]   = ev_ovf;
    fifo_low[FIFO_WARN]  = ev_warn;
    fifo_low[FIFO_AVAIL] = ev_avail;
  end

  generate
    for (genvar g = 0; g < MB_MAX; g++) begin : g_lane
      if (g < FIFO_SPAN) begin : g_low
        assign set_vec[g] = fifo_en ? fifo_low[g] : done[g];
      end else begin : g_high
        assign set_vec[g] = done[g];
      end
    end
  endgenerate

  AST_FIFO_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |-> (set_vec[FIFO_AVAIL-1:0] == '0)); // R7
endmodule

// File: rtl/mbflag_bank.sv
module mbflag_bank
  import mbflag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MB_WORD-1:0] live,
  input  logic [MB_WORD-1:0] set_ev,
  input  logic               flag_wr,
  input  logic               mask_wr,
  input  logic [MB_WORD-1:0] wr_data,
  output logic [MB_WORD-1:0] flag_rd,
  output logic [MB_WORD-1:0] mask_q,
  output logic [MB_WORD-1:0] irq
);
  logic [MB_WORD-1:0] flag_q;
  logic [MB_WORD-1:0] clr_vec;
  logic [MB_WORD-1:0] set_live;
  logic [MB_WORD-1:0] flag_d;

  assign clr_vec  = flag_wr ? wr_data : '0;
  assign set_live = set_ev & live;
  assign flag_d   = ((flag_q & ~clr_vec) | set_live) & live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (mask_wr) mask_q <= wr_data;
    end
  end

  assign flag_rd = flag_q & live;
  assign irq     = flag_rd & mask_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(set_live)) == $past(set_live))); // R4
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> ((flag_q & $past(wr_data & ~set_ev)) == '0)); // R3
  AST_DEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(live)) == '0)); // R8
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wr_data))); // R10
endmodule

// File: rtl/mbflag_ctrl.sv
module mbflag_ctrl
  import mbflag_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MB_CNT_W-1:0] cfg_nbuf,
  input  logic                cfg_fifo_en,
  input  logic [MB_MAX-1:0]   mb_done,
  input  logic                fifo_ovf,
  input  logic                fifo_warn,
  input  logic                fifo_avail,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [MB_WORD-1:0]  wr_data,
  input  logic [1:0]          rd_sel,
  output logic [MB_WORD-1:0]  rd_data,
  output logic [MB_MAX-1:0]   buf_irq,
  output logic                any_irq
);
  logic [MB_MAX-1:0]  live_vec;
  logic [MB_MAX-1:0]  set_vec;
  logic [MB_WORD-1:0] flag_w [MB_NWORD];
  logic [MB_WORD-1:0] mask_w [MB_NWORD];

  assign live_vec = live_lanes(cfg_nbuf, cfg_fifo_en);

  mbflag_srcmap u_srcmap (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (cfg_fifo_en),
    .done     (mb_done),
    .ev_ovf   (fifo_ovf),
    .ev_warn  (fifo_warn),
    .ev_avail (fifo_avail),
    .set_vec  (set_vec)
  );

  generate
    for (genvar w = 0; w < MB_NWORD; w++) begin : g_word
      logic flag_wr_w;
      logic mask_wr_w;
      assign flag_wr_w = wr_en && !wr_sel[1] && (int'(wr_sel[0]) == w);
      assign mask_wr_w = wr_en &&  wr_sel[1] && (int'(wr_sel[0]) == w);
      mbflag_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (live_vec[w*MB_WORD +: MB_WORD]),
        .set_ev  (set_vec[w*MB_WORD +: MB_WORD]),
        .flag_wr (flag_wr_w),
        .mask_wr (mask_wr_w),
        .wr_data (wr_data),
        .flag_rd (flag_w[w]),
        .mask_q  (mask_w[w]),
        .irq     (buf_irq[w*MB_WORD +: MB_WORD])
      );
    end
  endgenerate

  always_comb begin
    rd_data = rd_sel[1] ? mask_w[rd_sel[0]] : flag_w[rd_sel[0]];
  end

  assign any_irq = |buf_irq;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (buf_irq == '0)); // R1
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_irq & ~live_vec) == '0); // R8
endmodule

// File: tb/mbflag_ctrl_bench.sv
`timescale 1ns/1ps
module mbflag_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  cfg_nbuf = 7'd64;
  logic        cfg_fifo_en = 1'b0;
  logic [63:0] mb_done = '0;
  logic        fifo_ovf = 1'b0, fifo_warn = 1'b0, fifo_avail = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'b00;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'b00;
  logic [31:0] rd_data;
  logic [63:0] buf_irq;
  logic        any_irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [63:0] m_flag = '0;
  logic [63:0] m_mask = '0;

  always #2 clk = ~clk;

  mbflag_ctrl u_mbflag_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_nbuf(cfg_nbuf), .cfg_fifo_en(cfg_fifo_en),
    .mb_done(mb_done), .fifo_ovf(fifo_ovf), .fifo_warn(fifo_warn),
    .fifo_avail(fifo_avail), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .buf_irq(buf_irq), .any_irq(any_irq)
  );

  function automatic logic [63:0] ref_live();
    logic [63:0] v = '0;
    int lim = (cfg_nbuf > 7'd64) ? 64 : int'(cfg_nbuf);
    for (int i = 0; i < lim; i++) v[i] = 1'b1;
    if (cfg_fifo_en) v[4:0] = '0;
    return v;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare all outputs, then clock once and advance the model.
  task automatic step(input string tag);
    logic [63:0] lv, exp_flag, exp_irq, setv, clrv;
    logic [31:0] exp_rd;
    #1;
    lv = ref_live();
    exp_flag = m_flag & lv;
    exp_irq  = exp_flag & m_mask;
    case (rd_sel)
      2'b00: exp_rd = exp_flag[31:0];
      2'b01: exp_rd = exp_flag[63:32];
      2'b10: exp_rd = m_mask[31:0];
      default: exp_rd = m_mask[63:32];
    endcase
    check({tag, " R5 buf_irq"}, buf_irq, exp_irq);
    check({tag, " R6 any_irq"}, {63'd0, any_irq}, {63'd0, |exp_irq});
    check({tag, " read"}, {32'd0, rd_data}, {32'd0, exp_rd});
    setv = mb_done;
    if (cfg_fifo_en) setv[7:0] = {fifo_ovf, fifo_warn, fifo_avail, 5'b0};
    clrv = '0;
    if (wr_en && !wr_sel[1]) begin
      if (wr_sel[0]) clrv[63:32] = wr_data; else clrv[31:0] = wr_data;
    end
    @(posedge clk);
    m_flag = ((m_flag & ~clrv) | setv) & lv;
    if (wr_en && wr_sel[1]) begin
      if (wr_sel[0]) m_mask[63:32] = wr_data; else m_mask[31:0] = wr_data;
    end
    @(negedge clk);
    mb_done = '0; fifo_ovf = 0; fifo_warn = 0; fifo_avail = 0; wr_en = 0;
    rd_sel = rd_sel + 2'd1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      rd_sel = 2'(k);
      #1 check("R1 reset read", {32'd0, rd_data}, 64'd0);
    end
    check("R1 reset irq", buf_irq, 64'd0);
    rst_n = 1;
    @(negedge clk);
    rd_sel = 0;
    step("R1");
    // R10: mask load
    wr(2'b10, 32'hFFFF_FFFF); step("R10");
    wr(2'b11, 32'hFFFF_FFFF); step("R10");
    // R2: single and walking pulses
    mb_done[0] = 1; step("R2");
    mb_done[63] = 1; step("R2");
    for (int i = 0; i < 64; i++) begin mb_done[i] = 1; step("R2 walk"); end
    // R3: checkerboard clears
    wr(2'b00, 32'hAAAA_AAAA); step("R3");
    wr(2'b01, 32'h0000_0000); step("R3");
    wr(2'b01, 32'h5555_5555); step("R3");
    step("R3"); step("R3"); step("R3");
    // R4: set beats clear
    mb_done = 64'hFFFF_FFFF_FFFF_FFFF; step("R4");
    wr(2'b00, 32'hFFFF_FFFF); mb_done[31:0] = 32'h0F0F_0F0F; step("R4");
    rd_sel = 2'b00; step("R4 readback");
    // R10: partial mask, R5
    wr(2'b10, 32'h00FF_00FF); step("R10"); step("R5"); step("R5");
    // R8/R9: count changes
    cfg_nbuf = 7'd40; step("R9"); step("R8");
    mb_done = '1; step("R8"); step("R8");
    cfg_nbuf = 7'd64; step("R9 stay cleared"); step("R9"); step("R9"); step("R9");
    cfg_nbuf = 7'd0; mb_done = '1; step("R8 zero"); step("R8");
    cfg_nbuf = 7'd100; mb_done = '1; step("R8 over"); step("R8");
    // R7: FIFO mode
    cfg_fifo_en = 1; step("R7 dead"); step("R7");
    wr(2'b00, 32'hFFFF_FFFF); step("R7");
    mb_done[7:0] = 8'hFF; step("R7 ignore"); step("R7");
    fifo_ovf = 1; step("R7 ovf");
    fifo_warn = 1; step("R7 warn");
    fifo_avail = 1; step("R7 avail"); step("R7"); step("R7"); step("R7");
    cfg_fifo_en = 0; step("R7 exit"); step("R7"); step("R7"); step("R7");
    // random mix
    for (int n = 0; n < 600; n++) begin
      mb_done = {$urandom, $urandom} & {$urandom, $urandom};
      fifo_ovf = $urandom; fifo_warn = $urandom; fifo_avail = $urandom;
      if (($urandom % 3) == 0) wr(2'($urandom), $urandom);
      if (($urandom % 40) == 0) cfg_fifo_en = $urandom;
      if (($urandom % 50) == 0) cfg_nbuf = 7'($urandom % 70);
      step("R2 R3 R4 R7 R8 random");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule